// File: doc/BRIEF.md
# Banked Memory Read/Write Controller

This block sits between a CPU with a 16-bit address bus and a physical memory array that is larger than that bus can reach. It splits the CPU space into eight windows of 8 KB each, and it maps each window onto one 8 KB physical segment for reads. Reads and writes are steered separately. A read comes from exactly one segment per window. A write can land in up to four physical banks in the same cycle, which lets software fill several planes, such as colour planes of video memory, with one store.

Software sets the routing by writing one 8-bit bank control byte through an I/O port. The upper nibble holds write enables and the lower nibble holds read selects. A neighbouring disk-control port passes in one mode bit, and that bit changes what the top window reads in one mode. The block gives out the physical read address (segment index followed by the 13-bit window offset) and one write strobe per bank. The memory arrays sit outside the block.

Top module: `banked_mem_ctrl`

## Requirements
- R1: After reset the stored control byte is 0x00 and the mode bit is 0. With no further write, windows 0-2 read segments 0-2, windows 3-6 read segments 11-14, window 7 reads segment 7, and a CPU write strobes bank 1 only.
- R2: The control byte is XORed with 0x8C to form active-high lines. Bit 7 enables writes to bank 1, bit 6 to bank 2, bit 5 to bank 3 and bit 4 to bank 4. Bit 3 selects ROM reads, bit 2 bank 1, bit 1 bank 2 and bit 0 bank 4.
- R3: With no read line active, or with only ROM active, window w reads segment w.
- R4: With one of the banks alone active, window w reads segment 8+w for bank 1, 16+w for bank 2 and 32+w for bank 4.
- R5: With ROM and a bank both active, windows 0-2 read segments 0-2 and windows 3-7 read the bank's segments for those windows.
- R6: With ROM and bank 1 active, window 7 reads segment 15 when the mode bit is 1 and segment 7 when it is 0.
- R7: Bank 1 outranks bank 2 and bank 4, and bank 2 outranks bank 4. An active bank-1 line cancels the bank-4 line.
- R8: wr_strobe_o[k] is high when cpu_we_i is high and the write line for bank k+1 is active. Several strobes may be high together, and all are low when cpu_we_i is low.
- R9: A mode_wr_i pulse changes the read map at once from the stored control byte, without a new control write. Where R6 does not apply, the mode bit has no effect.
- R10: A control write takes effect on the clock edge. A CPU access in the same cycle as the control write uses the previous byte, and the new byte applies from the next cycle.
- R11: The low 13 bits of rd_addr_o equal the low 13 bits of cpu_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Write strobe for the bank control byte |
| ctl_data_i | input | 8 | Bank control byte |
| mode_wr_i | input | 1 | Write strobe for the mode bit |
| mode_bit_i | input | 1 | Mode bit (bit 4 of the disk-control port) |
| cpu_addr_i | input | 16 | CPU address |
| cpu_we_i | input | 1 | CPU memory write enable |
| rd_addr_o | output | 19 | Physical read address: segment index followed by the offset |
| wr_strobe_o | output | 4 | Write strobes for banks 1 to 4, bit 0 = bank 1 |

## Verification
A control write and a CPU access can fall in the same cycle. In that cycle the access must still use the old routing. The bench provokes this by raising ctl_wr_i together with cpu_we_i, after loading a byte that enables all four write banks. It then checks the read segment and the strobes before the edge against the old byte, and after the edge against the new byte. The same collision between a mode write and a read of the top window is judged in the same way: the remap must appear only after the edge.

// File: rtl/banked_mem_pkg.sv
package banked_mem_pkg;
  localparam logic [7:0] CTL_POL = 8'h8C;

  typedef enum logic [1:0] {
    SRC_ROM = 2'd0,
    SRC_B1  = 2'd1,
    SRC_B2  = 2'd2,
    SRC_B4  = 2'd3
  } rd_src_e;

  typedef struct packed {
    rd_src_e src;
    logic    overlay;
  } rd_plan_t;
endpackage

// File: rtl/bmc_ctl_regs.sv
module bmc_ctl_regs
  import banked_mem_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_wr_i,
  input  logic [7:0] ctl_data_i,
  input  logic       mode_wr_i,
  input  logic       mode_bit_i,
  output logic [7:0] sel_o,
  output logic       mode_o
);
  logic [7:0] bank_q;
  logic       mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      mode_q <= 1'b0;
    end else begin
      if (ctl_wr_i)  bank_q <= ctl_data_i;
      if (mode_wr_i) mode_q <= mode_bit_i;
    end
  end

  // mixed polarity normalised to active high
  assign sel_o  = bank_q ^ CTL_POL;
  assign mode_o = mode_q;
endmodule

// File: rtl/bmc_rd_decode.sv
module bmc_rd_decode
  import banked_mem_pkg::*;
(
  input  logic [3:0] rd_sel_i,   // [3]=rom [2]=b1 [1]=b2 [0]=b4
  output rd_plan_t   plan_o
);
  logic rom, b1, b2, b4;

  always_comb begin
    rom = rd_sel_i[3];
    b1  = rd_sel_i[2];
    b2  = rd_sel_i[1];
    b4  = rd_sel_i[0] & ~b1;     // b1 gates off b4
    if (b1)      plan_o.src = SRC_B1;
    else if (b2) plan_o.src = SRC_B2;
    else if (b4) plan_o.src = SRC_B4;
    else         plan_o.src = SRC_ROM;
    plan_o.overlay = rom && (plan_o.src != SRC_ROM);
  end
endmodule

// File: rtl/bmc_win_map.sv
module bmc_win_map
  import banked_mem_pkg::*;
#(
  parameter int WIN_W    = 3,
  parameter int SEG_W    = 6,
  parameter int ROM_WINS = 3,
  parameter int B1_BASE  = 8,
  parameter int B2_BASE  = 16,
  parameter int B4_BASE  = 32,
  localparam int WIN_N   = 1 << WIN_W
) (
  input  rd_plan_t             plan_i,
  input  logic                 mode_i,
  input  logic [WIN_W-1:0]     win_i,
  output logic [SEG_W-1:0]     seg_o
);
  logic [SEG_W-1:0] base;
  logic [WIN_N-1:0][SEG_W-1:0] seg_tab;

  always_comb begin
    unique case (plan_i.src)
      SRC_B1:  base = SEG_W'(B1_BASE);
      SRC_B2:  base = SEG_W'(B2_BASE);
      SRC_B4:  base = SEG_W'(B4_BASE);
      default: base = '0;
    endcase
  end

  for (genvar w = 0; w < WIN_N; w++) begin : g_win
    always_comb begin
      if (plan_i.overlay && (w < ROM_WINS))
        seg_tab[w] = SEG_W'(w);
      else if (plan_i.overlay && (plan_i.src == SRC_B1) && (w == WIN_N - 1) && !mode_i)
        seg_tab[w] = SEG_W'(w);            // top window falls back to ROM
      else
        seg_tab[w] = base + SEG_W'(w);
    end
  end

  assign seg_o = seg_tab[win_i];
endmodule

// File: rtl/bmc_wr_fanout.sv
module bmc_wr_fanout #(
  parameter int NUM_WB = 4
) (
  input  logic [NUM_WB-1:0] wr_sel_i,   // msb = bank 1
  input  logic              we_i,
  output logic [NUM_WB-1:0] strobe_o    // lsb = bank 1
);
  for (genvar k = 0; k < NUM_WB; k++) begin : g_bank
    assign strobe_o[k] = we_i & wr_sel_i[NUM_WB-1-k];
  end
endmodule

// File: rtl/banked_mem_ctrl.sv
module banked_mem_ctrl
  import banked_mem_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_W    = 3,
  parameter int SEG_W    = 6,
  parameter int ROM_WINS = 3,
  parameter int B1_BASE  = 8,
  parameter int B2_BASE  = 16,
  parameter int B4_BASE  = 32,
  localparam int OFS_W   = ADDR_W - WIN_W,
  localparam int PHYS_W  = SEG_W + OFS_W,
  localparam int NUM_WB  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [7:0]        ctl_data_i,
  input  logic              mode_wr_i,
  input  logic              mode_bit_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_we_i,
  output logic [PHYS_W-1:0] rd_addr_o,
  output logic [NUM_WB-1:0] wr_strobe_o
);
  logic [7:0]       sel;
  logic             mode;
  rd_plan_t         plan;
  logic [SEG_W-1:0] seg;

  bmc_ctl_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_data_i (ctl_data_i),
    .mode_wr_i  (mode_wr_i),
    .mode_bit_i (mode_bit_i),
    .sel_o      (sel),
    .mode_o     (mode)
  );

  bmc_rd_decode u_dec (
    .rd_sel_i (sel[3:0]),
    .plan_o   (plan)
  );

  bmc_win_map #(
    .WIN_W    (WIN_W),
    .SEG_W    (SEG_W),
    .ROM_WINS (ROM_WINS),
    .B1_BASE  (B1_BASE),
    .B2_BASE  (B2_BASE),
    .B4_BASE  (B4_BASE)
  ) u_map (
    .plan_i (plan),
    .mode_i (mode),
    .win_i  (cpu_addr_i[ADDR_W-1 -: WIN_W]),
    .seg_o  (seg)
  );

  bmc_wr_fanout #(.NUM_WB(NUM_WB)) u_wr (
    .wr_sel_i (sel[7:4]),
    .we_i     (cpu_we_i),
    .strobe_o (wr_strobe_o)
  );

  assign rd_addr_o = {seg, cpu_addr_i[OFS_W-1:0]};
endmodule

// File: rtl/bmc_chk.sv
module bmc_chk #(
  parameter int ADDR_W    = 16,
  parameter int WIN_W     = 3,
  parameter int SEG_W     = 6,
  parameter int ROM_WINS  = 3,
  parameter int SEG_LIMIT = 40,
  localparam int OFS_W    = ADDR_W - WIN_W,
  localparam int PHYS_W   = SEG_W + OFS_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctl_wr_i,
  input logic [7:0]        ctl_data_i,
  input logic              mode_wr_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_we_i,
  input logic [PHYS_W-1:0] rd_addr_o,
  input logic [3:0]        wr_strobe_o
);
  // R8
  idle_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_we_i |-> (wr_strobe_o == 4'b0000));

  // R11
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_o[OFS_W-1:0] == cpu_addr_i[OFS_W-1:0]);

  // R5
  rom_low_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctl_wr_i) && !$past(ctl_data_i[3]) && !ctl_wr_i &&
     (int'(cpu_addr_i[ADDR_W-1 -: WIN_W]) < ROM_WINS))
    |-> (rd_addr_o[PHYS_W-1 -: SEG_W] == SEG_W'(cpu_addr_i[ADDR_W-1 -: WIN_W])));

  // R10
  map_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(ctl_wr_i) && !$past(mode_wr_i) && $stable(cpu_addr_i)) |-> $stable(rd_addr_o));

  // R4
  seg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rd_addr_o[PHYS_W-1 -: SEG_W]) < SEG_LIMIT);

  // R2
  bank1_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ctl_wr_i) && !$past(ctl_data_i[7]) && cpu_we_i) |-> wr_strobe_o[0]);
endmodule

bind banked_mem_ctrl bmc_chk #(
  .ADDR_W    (ADDR_W),
  .WIN_W     (WIN_W),
  .SEG_W     (SEG_W),
  .ROM_WINS  (ROM_WINS),
  .SEG_LIMIT (B4_BASE + (1 << WIN_W))
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_wr_i    (ctl_wr_i),
  .ctl_data_i  (ctl_data_i),
  .mode_wr_i   (mode_wr_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_we_i    (cpu_we_i),
  .rd_addr_o   (rd_addr_o),
  .wr_strobe_o (wr_strobe_o)
);

// File: tb/tb_banked_mem_ctrl.sv
module tb_banked_mem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_data = '0;
  logic        mode_wr = 1'b0;
  logic        mode_bit = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [18:0] rd_addr;
  logic [3:0]  wr_strobe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  banked_mem_ctrl dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctl_wr_i    (ctl_wr),
    .ctl_data_i  (ctl_data),
    .mode_wr_i   (mode_wr),
    .mode_bit_i  (mode_bit),
    .cpu_addr_i  (cpu_addr),
    .cpu_we_i    (cpu_we),
    .rd_addr_o   (rd_addr),
    .wr_strobe_o (wr_strobe)
  );

  // {ctl, mode, we, addr, expected segment, expected strobes}
  localparam int NV = 19;
  localparam logic [35:0] VEC [NV] = '{
    {8'h8C, 1'b0, 1'b0, 16'hA123, 6'd5,  4'h0},
    {8'h88, 1'b0, 1'b0, 16'h1234, 6'd8,  4'h0},
    {8'h8E, 1'b0, 1'b0, 16'hE001, 6'd23, 4'h0},
    {8'h8D, 1'b0, 1'b0, 16'h6000, 6'd35, 4'h0},
    {8'h85, 1'b0, 1'b0, 16'h4567, 6'd2,  4'h0},
    {8'h85, 1'b0, 1'b0, 16'h8000, 6'd36, 4'h0},
    {8'h86, 1'b0, 1'b0, 16'hC010, 6'd22, 4'h0},
    {8'h80, 1'b0, 1'b0, 16'hFFFF, 6'd7,  4'h0},
    {8'h80, 1'b1, 1'b0, 16'hFFFF, 6'd15, 4'h0},
    {8'h80, 1'b1, 1'b0, 16'h7FFF, 6'd11, 4'h0},
    {8'h8B, 1'b0, 1'b0, 16'h2000, 6'd9,  4'h0},
    {8'h8F, 1'b0, 1'b0, 16'h2000, 6'd17, 4'h0},
    {8'h81, 1'b0, 1'b0, 16'h6000, 6'd11, 4'h0},
    {8'h84, 1'b1, 1'b0, 16'hE000, 6'd7,  4'h0},
    {8'h0C, 1'b0, 1'b1, 16'h0000, 6'd0,  4'h1},
    {8'hFC, 1'b0, 1'b1, 16'h3000, 6'd1,  4'hE},
    {8'h7C, 1'b0, 1'b1, 16'h5000, 6'd2,  4'hF},
    {8'h8C, 1'b0, 1'b1, 16'h0000, 6'd0,  4'h0},
    {8'h7C, 1'b0, 1'b0, 16'h5000, 6'd2,  4'h0}
  };

  function automatic string tag_of(input int i);
    if (i == 0 || i == 13) return "R3";
    if (i <= 3)  return "R2/R4";
    if (i <= 6)  return "R5";
    if (i <= 9)  return "R6";
    if (i <= 12) return "R7";
    return "R8";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [15:0] a,
                         input int seg, input int strb);
    chk(req, int'(rd_addr[18:13]), seg);
    chk({req, " offset R11"}, int'(rd_addr[12:0]), int'(a[12:0]));
    chk({req, " strobe"}, int'(wr_strobe), strb);
  endtask

  task automatic load(input logic [7:0] c, input logic m);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_data = c; mode_wr = 1'b1; mode_bit = m; cpu_we = 1'b0;
    @(negedge clk);
    ctl_wr = 1'b0; mode_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    cpu_addr = 16'hE000; #1 chk_out("R1 top", cpu_addr, 7, 0);
    cpu_addr = 16'h6000; #1 chk_out("R1 mid", cpu_addr, 11, 0);
    cpu_addr = 16'h0000; cpu_we = 1'b1; #1 chk_out("R1 low", cpu_addr, 0, 1);
    cpu_we = 1'b0;

    // table walk
    for (int i = 0; i < NV; i++) begin
      load(VEC[i][35:28], VEC[i][27]);
      cpu_addr = VEC[i][25:10];
      cpu_we   = VEC[i][26];
      #1 chk_out(tag_of(i), cpu_addr, int'(VEC[i][9:4]), int'(VEC[i][3:0]));
      cpu_we = 1'b0;
    end

    // R9 mode change alone remaps the top window
    load(8'h80, 1'b0);
    cpu_addr = 16'hE000;
    #1 chk_out("R9 before", cpu_addr, 7, 0);
    @(negedge clk); mode_wr = 1'b1; mode_bit = 1'b1;
    #1 chk_out("R9 same cycle", cpu_addr, 7, 0);
    @(negedge clk); mode_wr = 1'b0;
    #1 chk_out("R9 after set", cpu_addr, 15, 0);
    @(negedge clk); mode_wr = 1'b1; mode_bit = 1'b0;
    @(negedge clk); mode_wr = 1'b0;
    #1 chk_out("R9 after clear", cpu_addr, 7, 0);
    load(8'h85, 1'b0);
    #1 chk_out("R9 no effect m0", cpu_addr, 39, 0);
    @(negedge clk); mode_wr = 1'b1; mode_bit = 1'b1;
    @(negedge clk); mode_wr = 1'b0;
    #1 chk_out("R9 no effect m1", cpu_addr, 39, 0);

    // R10 control write collides with CPU write
    load(8'h7C, 1'b0);
    @(negedge clk);
    cpu_addr = 16'h6000; cpu_we = 1'b1;
    ctl_wr = 1'b1; ctl_data = 8'h00;
    #1 chk_out("R10 old byte", cpu_addr, 3, 15);
    @(negedge clk);
    ctl_wr = 1'b0;
    #1 chk_out("R10 new byte", cpu_addr, 11, 1);
    cpu_we = 1'b0;

    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule